// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches a single external pin and raises an interrupt request towards a CPU when the pin shows the edge that software has selected. Software reaches two byte-wide registers over a simple write/read port. The first selects which edge counts: rising, falling, both, or none. The second holds the source enable, the request flag and the global interrupt enable. While the request is active, the block presents a fixed vector address to the CPU. The CPU's interrupt-entry acknowledge clears the global enable, which takes the request away until software enables it again.

The pin is asynchronous. In normal operation it passes through a two-flop synchronizer, and each edge is found by comparing the synchronized value with the value one cycle older. While the system is in power-down, that path is ignored. Instead, an edge-triggered capture that needs no clock records a matching edge and raises the wake-up output at once. When power-down ends, the captured edge sets the request flag before anything else happens, so the interrupt is taken first. The capture then clears itself. The register port is plain control: writes take effect on the clock edge, and reads are combinational from the address.

Top module: `pin_edge_irq`

## Requirements
- R1: The edge-select register at address 0xBF holds bits [1:0] read/write, and its upper bits read 0. The control register at 0xC0 has bit 0 as the source enable, bit 1 as the request flag and bit 2 as the global enable, with bits [7:3] reading 0. Any other address reads 0. All fields reset to 0.
- R2: Edge-select code 01 counts rising edges, 10 counts falling edges and 11 counts both. A pin change applied before clock edge 1 sets the flag at clock edge 3.
- R3: With edge-select code 00, no edge sets the flag and no edge raises the wake-up output.
- R4: While the source enable is 0, edges leave the flag unchanged, and no such edge is remembered once the enable is turned on.
- R5: Writing the control register with bit 1 = 0 clears the flag. Writing bit 1 = 1 never sets it.
- R6: When a qualifying edge and a software clear of the flag land on the same clock edge, the flag ends up set.
- R7: `irq_o` is 1 exactly when the flag, the source enable and the global enable are all 1. While `irq_o` is 1, `vec_o` reads 0x08, and it reads 0x00 otherwise.
- R8: `irq_ack_i` high at a clock edge clears the global enable, so `irq_o` is 0 from that edge on.
- R9: With `pwr_down_i` high, the source enable on and a matching edge code selected, a matching pin edge raises `wake_o` without waiting for a clock edge. The synchronized edge path does not set the flag during power-down.
- R10: After `pwr_down_i` falls, a captured wake edge sets the flag within 6 cycles and `wake_o` returns to 0.
- R11: A pin edge in power-down whose direction does not match the selected code raises no wake-up and leaves the flag at 0 after power-down ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External pin, asynchronous |
| pwr_down_i | input | 1 | System is in power-down |
| bus_addr_i | input | 8 | Register address for both read and write |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| irq_ack_i | input | 1 | CPU interrupt-entry acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector address, valid while irq_o is 1 |
| wake_o | output | 1 | Wake-up request from the power-down capture |

## Verification
Two things can fall on the same clock edge: a hardware set of the flag from a synchronized edge, and a software write that clears the flag. The bench provokes this by changing the pin and then issuing the clearing write exactly two cycles later, which is the edge where the synchronized change reaches the flag. It then judges the result by reading back the flag, which must be 1. A behavioural model, stepped once per clock, predicts the flag, the register reads and the request every cycle, and the bench compares all of them against the design.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int CTRL_IEN  = 0;
  localparam int CTRL_FLAG = 1;
  localparam int CTRL_GIE  = 2;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pei_edge_det.sv
module pei_edge_det
  import pin_edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  edge_mode_e mode_i,
  input  logic       block_i,
  output logic       hit_o
);
  logic prev_q;
  logic rose, fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_i;
  end

  assign rose  = sync_i & ~prev_q;
  assign fell  = ~sync_i & prev_q;
  assign hit_o = ~block_i & ((mode_i[0] & rose) | (mode_i[1] & fell));
endmodule

// File: rtl/pei_wake_latch.sv
module pei_wake_latch
  import pin_edge_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       pwr_down_i,
  input  logic       arm_i,
  input  edge_mode_e mode_i,
  output logic       wake_o,
  output logic       set_o
);
  logic rise_q, fall_q;
  logic clr_q;
  logic held_s;
  logic cap_rise, cap_fall;
  logic async_clr;

  assign cap_rise  = pwr_down_i & arm_i & mode_i[0];
  assign cap_fall  = pwr_down_i & arm_i & mode_i[1];
  assign async_clr = clr_q | ~rst_n;

  always_ff @(posedge pin_i or posedge async_clr) begin
    if (async_clr)     rise_q <= 1'b0;
    else if (cap_rise) rise_q <= 1'b1;
  end

  always_ff @(negedge pin_i or posedge async_clr) begin
    if (async_clr)     fall_q <= 1'b0;
    else if (cap_fall) fall_q <= 1'b1;
  end

  assign wake_o = rise_q | fall_q;

  pei_sync #(.STAGES(SYNC_STAGES)) u_held_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (wake_o),
    .q_o   (held_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= held_s & ~pwr_down_i;
  end

  assign set_o = held_s & ~pwr_down_i & ~clr_q;

  AST_WAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o) else $error("wake set repeated"); // R10
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pin_edge_irq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  EDGE_ADDR = 8'hBF,
  parameter logic [7:0]  CTRL_ADDR = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              set_i,
  input  logic              ack_i,
  output edge_mode_e        mode_o,
  output logic              ien_o,
  output logic              flag_o,
  output logic              gie_o
);
  localparam int MODE_W = 2;

  edge_mode_e mode_q;
  logic ien_q, flag_q, gie_q;
  logic wr_edge, wr_ctrl, sw_clear, hw_set;

  assign wr_edge  = wr_i && (addr_i == ADDR_W'(EDGE_ADDR));
  assign wr_ctrl  = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign sw_clear = wr_ctrl && !wdata_i[CTRL_FLAG];
  assign hw_set   = set_i && ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= EDGE_NONE;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      if (wr_edge) mode_q <= edge_mode_e'(wdata_i[MODE_W-1:0]);
      if (wr_ctrl) ien_q  <= wdata_i[CTRL_IEN];
      if (ack_i)        gie_q <= 1'b0;
      else if (wr_ctrl) gie_q <= wdata_i[CTRL_GIE];
      if (hw_set)        flag_q <= 1'b1;
      else if (sw_clear) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(EDGE_ADDR)) begin
      rdata_o[MODE_W-1:0] = mode_q;
    end else if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rdata_o[CTRL_IEN]  = ien_q;
      rdata_o[CTRL_FLAG] = flag_q;
      rdata_o[CTRL_GIE]  = gie_q;
    end
  end

  assign mode_o = mode_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;
  assign gie_o  = gie_q;

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i)) else $error("flag rose without source"); // R2
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !flag_q) |=> !flag_q) else $error("flag set while disabled"); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && ien_q && sw_clear) |=> flag_q) else $error("edge lost to clear"); // R6
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !gie_q) else $error("global enable survived ack"); // R8
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] EDGE_ADDR   = 8'hBF,
  parameter logic [7:0] CTRL_ADDR   = 8'hC0,
  parameter logic [7:0] VECTOR      = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              pwr_down_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [7:0]        vec_o,
  output logic              wake_o
);
  edge_mode_e mode;
  logic ien, flag, gie;
  logic pin_s, edge_hit, wake_set;

  pei_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  pei_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (pin_s),
    .mode_i  (mode),
    .block_i (pwr_down_i),
    .hit_o   (edge_hit)
  );

  pei_wake_latch #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .pwr_down_i (pwr_down_i),
    .arm_i      (ien),
    .mode_i     (mode),
    .wake_o     (wake_o),
    .set_o      (wake_set)
  );

  pei_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .EDGE_ADDR (EDGE_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .set_i   (edge_hit | wake_set),
    .ack_i   (irq_ack_i),
    .mode_o  (mode),
    .ien_o   (ien),
    .flag_o  (flag),
    .gie_o   (gie)
  );

  assign irq_o = flag & ien & gie;
  assign vec_o = irq_o ? VECTOR : 8'h00;

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_NONE && !flag && !wake_set) |=> !flag) else $error("reserved code set flag"); // R3
  AST_WAKE_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_set && ien) |=> flag) else $error("wake edge not serviced"); // R10
  AST_PD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |-> !edge_hit) else $error("edge path active in power-down"); // R9
endmodule

// File: tb/pin_edge_irq_bench.sv
module pin_edge_irq_bench;
  localparam logic [7:0] A_EDGE = 8'hBF;
  localparam logic [7:0] A_CTRL = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic pd = 1'b0;
  logic [7:0] addr = A_CTRL;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic ack = 1'b0;
  logic irq;
  logic [7:0] vec;
  logic wake;

  int total = 0;
  int bad = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [1:0] m_sel;
  logic m_ien, m_flag, m_gie;
  logic h1, h2, h3;

  always #5 clk = ~clk;

  pin_edge_irq u_pin_edge_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .pwr_down_i  (pd),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_ack_i   (ack),
    .irq_o       (irq),
    .vec_o       (vec),
    .wake_o      (wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic hit, nf, ng;
    if (!rst_n) begin
      m_sel = 2'b00; m_ien = 1'b0; m_flag = 1'b0; m_gie = 1'b0;
      h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    end else begin
      hit = !pd && ((m_sel[0] && h2 && !h3) || (m_sel[1] && !h2 && h3));
      nf = m_flag;
      ng = m_gie;
      if (wr && addr == A_CTRL && !wdata[1]) nf = 1'b0;
      if (hit && m_ien) nf = 1'b1;
      if (wr && addr == A_CTRL) ng = wdata[2];
      if (ack) ng = 1'b0;
      if (wr && addr == A_EDGE) m_sel = wdata[1:0];
      if (wr && addr == A_CTRL) m_ien = wdata[0];
      m_flag = nf;
      m_gie = ng;
      h3 = h2; h2 = h1; h1 = pin;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    logic exp_irq;
    if (rst_n && model_on) begin
      exp_rd = 8'h00;
      if (addr == A_EDGE) exp_rd = {6'b0, m_sel};
      else if (addr == A_CTRL) exp_rd = {5'b0, m_gie, m_flag, m_ien};
      exp_irq = m_flag & m_ien & m_gie;
      chk("R1", rdata, exp_rd);
      chk("R7", irq, exp_irq);
      chk("R7", vec, exp_irq ? 8'h08 : 8'h00);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = A_CTRL;
  endtask

  task automatic move_pin(input logic v);
    @(negedge clk);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_flag(input string req, input logic exp);
    #1;
    chk(req, rdata[1], exp);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    addr = A_EDGE; #1 chk("R1", rdata, 8'h00);
    addr = A_CTRL; #1 chk("R1", rdata, 8'h00);
    addr = 8'h10;  #1 chk("R1", rdata, 8'h00);
    addr = A_CTRL;
    chk("R9", wake, 0);

    // rising only
    bus_wr(A_CTRL, 8'h01);
    bus_wr(A_EDGE, 8'hFD);
    addr = A_EDGE; #1 chk("R1", rdata, 8'h01); addr = A_CTRL;
    move_pin(1'b1); rd_flag("R2", 1'b1);
    bus_wr(A_CTRL, 8'h01); rd_flag("R5", 1'b0);
    move_pin(1'b0); rd_flag("R2", 1'b0);
    // falling only
    bus_wr(A_EDGE, 8'h02);
    move_pin(1'b1); rd_flag("R2", 1'b0);
    move_pin(1'b0); rd_flag("R2", 1'b1);
    bus_wr(A_CTRL, 8'h01);
    // both edges
    bus_wr(A_EDGE, 8'h03);
    move_pin(1'b1); rd_flag("R2", 1'b1);
    bus_wr(A_CTRL, 8'h01);
    move_pin(1'b0); rd_flag("R2", 1'b1);
    bus_wr(A_CTRL, 8'h01);
    // reserved code
    bus_wr(A_EDGE, 8'h00);
    move_pin(1'b1); rd_flag("R3", 1'b0);
    move_pin(1'b0); rd_flag("R3", 1'b0);
    // enable off
    bus_wr(A_EDGE, 8'h03);
    bus_wr(A_CTRL, 8'h00);
    move_pin(1'b1); rd_flag("R4", 1'b0);
    bus_wr(A_CTRL, 8'h01);
    repeat (3) @(negedge clk); rd_flag("R4", 1'b0);
    // writing 1 to flag does not set it
    bus_wr(A_CTRL, 8'h03); rd_flag("R5", 1'b0);
    // set and clear on the same edge
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = A_CTRL; wdata = 8'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_flag("R6", 1'b1);
    // request and acknowledge
    bus_wr(A_CTRL, 8'h07);
    #1 chk("R7", irq, 1'b1); chk("R7", vec, 8'h08);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1 chk("R8", irq, 1'b0); chk("R8", rdata[2], 1'b0);

    // power-down cases, directed checks only
    model_on = 1'b0;
    bus_wr(A_CTRL, 8'h01);
    bus_wr(A_EDGE, 8'h01);
    @(negedge clk); pd = 1'b1;
    repeat (3) @(negedge clk);
    pin = 1'b1;
    #2 chk("R9", wake, 1'b1);
    repeat (5) @(negedge clk); rd_flag("R9", 1'b0);
    @(negedge clk); pd = 1'b0;
    repeat (6) @(negedge clk);
    rd_flag("R10", 1'b1);
    chk("R10", wake, 1'b0);

    bus_wr(A_CTRL, 8'h01);
    @(negedge clk); pd = 1'b1;
    repeat (2) @(negedge clk);
    pin = 1'b0;
    #2 chk("R11", wake, 1'b0);
    repeat (3) @(negedge clk); pd = 1'b0;
    repeat (6) @(negedge clk); rd_flag("R11", 1'b0);

    bus_wr(A_EDGE, 8'h00);
    @(negedge clk); pd = 1'b1;
    repeat (2) @(negedge clk);
    pin = 1'b1;
    #2 chk("R3", wake, 1'b0);
    repeat (3) @(negedge clk); pd = 1'b0;
    repeat (6) @(negedge clk); rd_flag("R3", 1'b0);

    bus_wr(A_EDGE, 8'h03);
    @(negedge clk); pd = 1'b1;
    repeat (2) @(negedge clk);
    pin = 1'b0;
    #2 chk("R9", wake, 1'b1);
    repeat (3) @(negedge clk); pd = 1'b0;
    repeat (6) @(negedge clk);
    rd_flag("R10", 1'b1);
    chk("R10", wake, 1'b0);
    bus_wr(A_CTRL, 8'h07);
    #1 chk("R10", irq, 1'b1);

    finished = 1'b1;
    summary();
  end
endmodule